// File: doc/BRIEF.md
# Translation Fault Classifier

This block sits next to a small, fully associative translation table. For each memory access it decides whether the access translates, and if it does not, which memory-management fault the access raises. A request carries a virtual page number, a process tag, the kind of access and the processor's exception-in-progress flag. One cycle after the request strobe the block presents a hit flag, the physical frame, a one-cycle fault strobe, a 3-bit fault code and a flag that marks data-side misses.

A miss is reported as an ordinary refill miss. If the processor is already inside an exception handler, the same miss is reported as a nested miss instead. A handler can tell an instruction miss from a data miss by the code or by the data-side flag.

Access rights are checked only when the lookup hits. Address-based cache maintenance operations can miss, but they never fault on rights. Index-based cache maintenance operations do not translate at all. Table entries are loaded through a simple indexed write port.

Top module: `mmu_fault_classifier`

## Requirements
- R1: After reset every table entry is invalid, and hit, frame, code, data-side flag and fault strobe are all 0.
- R2: An access whose kind translates hits when a valid entry has an equal page tag and its tag check passes. The tag check passes when the entry's global bit is set, when `pid_chk_en` is 0, or when the process tags are equal. On a hit, the hit flag is 1 and the frame is the entry's frame, registered on the clock edge that samples the request.
- R3: If several entries match, the entry with the lowest index supplies the frame and the rights.
- R4: Access kind codes are 0 fetch, 1 load, 2 store, 3 index-invalidate, 4 address-invalidate, 5 index-writeback, 6 address-writeback; code 7 is unused. On a miss with `in_exc` equal to 0, the fault code is 1 for a fetch and 2 for kinds 1, 2, 4 and 6.
- R5: On a miss with `in_exc` equal to 1, the fault code is 3 for a fetch and 4 for kinds 1, 2, 4 and 6.
- R6: The data-side flag is 1 exactly when the fault is a miss of kind 1, 2, 4 or 6 (codes 2 and 4); otherwise it is 0.
- R7: Rights are checked on a hit, and a miss takes precedence over them. A fetch without execute right gives code 5, a load without read right gives code 6, and a store without write right gives code 7.
- R8: Kinds 4 and 6 never raise codes 5, 6 or 7. When they hit, whatever the entry's rights, they give code 0 and hit 1.
- R9: Kinds 3, 5 and 7 do no translation. They give hit 0, frame 0 and code 0, and raise no fault, whatever the table holds.
- R10: `fault` is high for exactly the one cycle after a request whose code is nonzero. With no request, hit, frame, code and data-side flag hold their values.
- R11: A write with `wr_en` set replaces entry `wr_idx` at the clock edge. A lookup in the same cycle still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Lookup request strobe |
| acc_kind | input | 3 | Access kind code |
| vpage | input | VPN_W | Virtual page number |
| proc_tag | input | PID_W | Current process tag |
| pid_chk_en | input | 1 | Include the process tag in the match |
| in_exc | input | 1 | Exception-in-progress flag |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | IDX_W | Entry index to write |
| wr_valid | input | 1 | Valid bit to write |
| wr_vpage | input | VPN_W | Page tag to write |
| wr_tag | input | PID_W | Process tag to write |
| wr_global | input | 1 | Global bit to write |
| wr_frame | input | PFN_W | Physical frame to write |
| wr_rd | input | 1 | Read right |
| wr_wr | input | 1 | Write right |
| wr_ex | input | 1 | Execute right |
| hit | output | 1 | Registered hit flag |
| frame | output | PFN_W | Registered frame, 0 when no hit |
| fault | output | 1 | One-cycle fault strobe |
| fault_code | output | 3 | Registered fault code |
| dside | output | 1 | Data-side miss flag |

## Verification
The bench goes after these corner cases:
- **Duplicate page tags.** A priority encoder reversed in direction would return the frame of the higher-index duplicate.
- **Each access kind on missing pages, hit pages and rights-denied pages, with the exception flag both clear and set.** A design that ignores the flag would never report a nested miss. One that checks rights before misses would raise rights codes on absent pages.
- **Cache maintenance ops on pages with no rights.** A design that forgets to exempt them would raise rights faults.
- **Index-based ops.** A design that treats them like data accesses would raise data misses.
- **A write to an entry in the same cycle as a lookup of its page, and PID mismatches under the global bit and with PID checking disabled.** Forwarding the write, or leaving out one of the tag bypasses, would show up as a wrong frame or a spurious miss.

// File: rtl/mmu_cls_pkg.sv
package mmu_cls_pkg;

  localparam logic [2:0] ACC_FETCH   = 3'd0;
  localparam logic [2:0] ACC_LOAD    = 3'd1;
  localparam logic [2:0] ACC_STORE   = 3'd2;
  localparam logic [2:0] ACC_IINV    = 3'd3;
  localparam logic [2:0] ACC_AINV    = 3'd4;
  localparam logic [2:0] ACC_IWB     = 3'd5;
  localparam logic [2:0] ACC_AWB     = 3'd6;

  localparam logic [2:0] FC_NONE     = 3'd0;
  localparam logic [2:0] FC_MISS_I   = 3'd1;
  localparam logic [2:0] FC_MISS_D   = 3'd2;
  localparam logic [2:0] FC_NEST_I   = 3'd3;
  localparam logic [2:0] FC_NEST_D   = 3'd4;
  localparam logic [2:0] FC_DENY_X   = 3'd5;
  localparam logic [2:0] FC_DENY_R   = 3'd6;
  localparam logic [2:0] FC_DENY_W   = 3'd7;

  // kinds that consult the translation table
  function automatic logic kind_translates(input logic [2:0] k);
    return (k == ACC_FETCH) || (k == ACC_LOAD) || (k == ACC_STORE) ||
           (k == ACC_AINV)  || (k == ACC_AWB);
  endfunction

  // kinds whose rights are checked on a hit
  function automatic logic kind_checks_rights(input logic [2:0] k);
    return (k == ACC_FETCH) || (k == ACC_LOAD) || (k == ACC_STORE);
  endfunction

  function automatic logic rights_allow(input logic [2:0] k, input logic r,
                                        input logic w, input logic x);
    case (k)
      ACC_FETCH: return x;
      ACC_LOAD:  return r;
      ACC_STORE: return w;
      default:   return 1'b1;
    endcase
  endfunction

  function automatic logic [2:0] miss_code(input logic data_side, input logic nested);
    if (nested) return data_side ? FC_NEST_D : FC_NEST_I;
    return data_side ? FC_MISS_D : FC_MISS_I;
  endfunction

  function automatic logic [2:0] deny_code(input logic [2:0] k);
    case (k)
      ACC_FETCH: return FC_DENY_X;
      ACC_LOAD:  return FC_DENY_R;
      default:   return FC_DENY_W;
    endcase
  endfunction

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PID_W   = 8,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [VPN_W-1:0] wr_vpage,
  input  logic [PID_W-1:0] wr_tag,
  input  logic             wr_global,
  input  logic [PFN_W-1:0] wr_frame,
  input  logic             wr_rd,
  input  logic             wr_wr,
  input  logic             wr_ex,
  output logic             e_valid  [ENTRIES],
  output logic [VPN_W-1:0] e_vpage  [ENTRIES],
  output logic [PID_W-1:0] e_tag    [ENTRIES],
  output logic             e_global [ENTRIES],
  output logic [PFN_W-1:0] e_frame  [ENTRIES],
  output logic [2:0]       e_rights [ENTRIES]
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   e_valid[g] <= 1'b0;
      else if (sel) e_valid[g] <= wr_valid;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        e_vpage[g]  <= wr_vpage;
        e_tag[g]    <= wr_tag;
        e_global[g] <= wr_global;
        e_frame[g]  <= wr_frame;
        e_rights[g] <= {wr_rd, wr_wr, wr_ex};
      end
    end
  end

endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PID_W   = 8,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             e_valid  [ENTRIES],
  input  logic [VPN_W-1:0] e_vpage  [ENTRIES],
  input  logic [PID_W-1:0] e_tag    [ENTRIES],
  input  logic             e_global [ENTRIES],
  input  logic [PFN_W-1:0] e_frame  [ENTRIES],
  input  logic [2:0]       e_rights [ENTRIES],
  input  logic [VPN_W-1:0] vpage,
  input  logic [PID_W-1:0] proc_tag,
  input  logic             pid_chk_en,
  output logic             any_hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic [PFN_W-1:0] sel_frame,
  output logic [2:0]       sel_rights
);

  logic [ENTRIES-1:0] match_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = e_valid[g] && (e_vpage[g] == vpage) &&
                          (e_global[g] || !pid_chk_en || (e_tag[g] == proc_tag));
  end

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign any_hit    = |match_vec;
  assign sel_frame  = e_frame[hit_idx];
  assign sel_rights = e_rights[hit_idx];

endmodule

// File: rtl/fault_encode.sv
module fault_encode
  import mmu_cls_pkg::*;
(
  input  logic [2:0] acc_kind,
  input  logic       in_exc,
  input  logic       any_hit,
  input  logic [2:0] rights,     // {read, write, execute}
  output logic       translates,
  output logic       miss_evt,
  output logic       deny_evt,
  output logic [2:0] code,
  output logic       data_miss
);

  logic allowed;

  assign translates = kind_translates(acc_kind);
  assign allowed    = rights_allow(acc_kind, rights[2], rights[1], rights[0]);
  assign miss_evt   = translates && !any_hit;
  assign deny_evt   = translates && any_hit && kind_checks_rights(acc_kind) && !allowed;
  assign data_miss  = miss_evt && (acc_kind != ACC_FETCH);

  always_comb begin
    if (miss_evt)      code = miss_code(acc_kind != ACC_FETCH, in_exc);
    else if (deny_evt) code = deny_code(acc_kind);
    else               code = FC_NONE;
  end

endmodule

// File: rtl/mmu_fault_classifier.sv
module mmu_fault_classifier #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PID_W   = 8,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [2:0]       acc_kind,
  input  logic [VPN_W-1:0] vpage,
  input  logic [PID_W-1:0] proc_tag,
  input  logic             pid_chk_en,
  input  logic             in_exc,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [VPN_W-1:0] wr_vpage,
  input  logic [PID_W-1:0] wr_tag,
  input  logic             wr_global,
  input  logic [PFN_W-1:0] wr_frame,
  input  logic             wr_rd,
  input  logic             wr_wr,
  input  logic             wr_ex,
  output logic             hit,
  output logic [PFN_W-1:0] frame,
  output logic             fault,
  output logic [2:0]       fault_code,
  output logic             dside
);

  logic             e_valid  [ENTRIES];
  logic [VPN_W-1:0] e_vpage  [ENTRIES];
  logic [PID_W-1:0] e_tag    [ENTRIES];
  logic             e_global [ENTRIES];
  logic [PFN_W-1:0] e_frame  [ENTRIES];
  logic [2:0]       e_rights [ENTRIES];

  logic             any_hit;
  logic [IDX_W-1:0] hit_idx;
  logic [PFN_W-1:0] sel_frame;
  logic [2:0]       sel_rights;
  logic             translates, miss_evt, deny_evt, data_miss;
  logic [2:0]       code;
  logic             xl_hit;

  tlb_entry_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W), .PFN_W(PFN_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
    .wr_vpage(wr_vpage), .wr_tag(wr_tag), .wr_global(wr_global), .wr_frame(wr_frame),
    .wr_rd(wr_rd), .wr_wr(wr_wr), .wr_ex(wr_ex),
    .e_valid(e_valid), .e_vpage(e_vpage), .e_tag(e_tag), .e_global(e_global),
    .e_frame(e_frame), .e_rights(e_rights)
  );

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W), .PFN_W(PFN_W)) u_match (
    .e_valid(e_valid), .e_vpage(e_vpage), .e_tag(e_tag), .e_global(e_global),
    .e_frame(e_frame), .e_rights(e_rights), .vpage(vpage), .proc_tag(proc_tag),
    .pid_chk_en(pid_chk_en), .any_hit(any_hit), .hit_idx(hit_idx),
    .sel_frame(sel_frame), .sel_rights(sel_rights)
  );

  fault_encode u_enc (
    .acc_kind(acc_kind), .in_exc(in_exc), .any_hit(any_hit), .rights(sel_rights),
    .translates(translates), .miss_evt(miss_evt), .deny_evt(deny_evt),
    .code(code), .data_miss(data_miss)
  );

  assign xl_hit = translates && any_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit        <= 1'b0;
      frame      <= '0;
      fault      <= 1'b0;
      fault_code <= 3'd0;
      dside      <= 1'b0;
    end else begin
      fault <= req && (code != 3'd0);
      if (req) begin
        hit        <= xl_hit;
        frame      <= xl_hit ? sel_frame : '0;
        fault_code <= code;
        dside      <= data_miss;
      end
    end
  end

endmodule

// File: rtl/mmu_cls_checker.sv
module mmu_cls_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req,
  input logic [2:0] acc_kind,
  input logic       in_exc,
  input logic       miss_evt,
  input logic       deny_evt,
  input logic       hit,
  input logic       fault,
  input logic [2:0] fault_code,
  input logic       dside
);

  // R10: a strobe only follows a request
  assert_strobe_after_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $past(req));

  // R10: after a request, strobe agrees with a nonzero code
  assert_strobe_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req) |-> (fault == (fault_code != 3'd0)));

  // R10: outputs hold without a request
  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> ($stable(fault_code) && $stable(hit) && $stable(dside)));

  // R5: nested miss codes only under the exception flag
  assert_nested_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && (fault_code == 3'd3 || fault_code == 3'd4)) |-> $past(in_exc));

  // R7: a rights fault implies a registered hit
  assert_deny_is_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && fault_code >= 3'd5) |-> hit);

  // R7: a detected rights event becomes a rights code
  assert_deny_reported_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && deny_evt) |=> (fault && fault_code >= 3'd5));

  // R4: a detected miss becomes a miss code with no hit
  assert_miss_reported_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req && miss_evt) |=> (fault && !hit && fault_code >= 3'd1 && fault_code <= 3'd4));

  // R8: address-based maintenance never raises rights faults
  assert_maint_no_deny_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && (acc_kind == 3'd4 || acc_kind == 3'd6)) |=> !(fault && fault_code >= 3'd5));

  // R9: non-translating kinds raise nothing
  assert_index_ops_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && (acc_kind == 3'd3 || acc_kind == 3'd5 || acc_kind == 3'd7)) |=> (!fault && !hit));

  // R6: data-side flag only with data miss codes
  assert_dside_codes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dside |-> (fault_code == 3'd2 || fault_code == 3'd4));

endmodule

bind mmu_fault_classifier mmu_cls_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .acc_kind(acc_kind), .in_exc(in_exc),
  .miss_evt(miss_evt), .deny_evt(deny_evt), .hit(hit), .fault(fault),
  .fault_code(fault_code), .dside(dside)
);

// File: tb/sim_mmu_fault_classifier.sv
module sim_mmu_fault_classifier;

  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 8;
  localparam int VPN_W = 20;
  localparam int PID_W = 8;
  localparam int PFN_W = 20;
  localparam int IDX_W = $clog2(ENTRIES);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [2:0] acc_kind = '0;
  logic [VPN_W-1:0] vpage = '0;
  logic [PID_W-1:0] proc_tag = '0;
  logic pid_chk_en = 1'b1;
  logic in_exc = 1'b0;
  logic wr_en = 1'b0;
  logic [IDX_W-1:0] wr_idx = '0;
  logic wr_valid = 1'b0;
  logic [VPN_W-1:0] wr_vpage = '0;
  logic [PID_W-1:0] wr_tag = '0;
  logic wr_global = 1'b0;
  logic [PFN_W-1:0] wr_frame = '0;
  logic wr_rd = 1'b0, wr_wr = 1'b0, wr_ex = 1'b0;
  logic hit, fault, dside;
  logic [PFN_W-1:0] frame;
  logic [2:0] fault_code;

  int n_tests = 0;
  int n_fail = 0;

  // reference state
  int m_valid [ENTRIES];
  int m_vpage [ENTRIES];
  int m_tag [ENTRIES];
  int m_glob [ENTRIES];
  int m_frame [ENTRIES];
  int m_r [ENTRIES], m_w [ENTRIES], m_x [ENTRIES];
  int x_hit = 0, x_frame = 0, x_fault = 0, x_code = 0, x_dside = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmu_fault_classifier u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .acc_kind(acc_kind), .vpage(vpage),
    .proc_tag(proc_tag), .pid_chk_en(pid_chk_en), .in_exc(in_exc),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_vpage(wr_vpage),
    .wr_tag(wr_tag), .wr_global(wr_global), .wr_frame(wr_frame),
    .wr_rd(wr_rd), .wr_wr(wr_wr), .wr_ex(wr_ex),
    .hit(hit), .frame(frame), .fault(fault), .fault_code(fault_code), .dside(dside)
  );

  task automatic check(input string tag, input int act, input int exp, input string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // predict the registered result from the current inputs and old table
  task automatic predict();
    int found, f_idx, data, xl, chk;
    found = 0; f_idx = 0;
    xl = (acc_kind inside {3'd0, 3'd1, 3'd2, 3'd4, 3'd6});
    chk = (acc_kind inside {3'd0, 3'd1, 3'd2});
    data = (acc_kind != 3'd0);
    for (int i = 0; i < ENTRIES; i++) begin
      if (!found && m_valid[i] != 0 && m_vpage[i] == int'(vpage) &&
          (m_glob[i] != 0 || !pid_chk_en || m_tag[i] == int'(proc_tag))) begin
        found = 1; f_idx = i;
      end
    end
    x_fault = 0;
    if (!req) return;
    if (!xl) begin
      x_hit = 0; x_frame = 0; x_code = 0; x_dside = 0;
    end else if (!found) begin
      x_hit = 0; x_frame = 0; x_dside = data;
      x_code = in_exc ? (data ? 4 : 3) : (data ? 2 : 1);
    end else begin
      x_hit = 1; x_frame = m_frame[f_idx]; x_dside = 0; x_code = 0;
      if (chk) begin
        if (acc_kind == 3'd0 && m_x[f_idx] == 0) x_code = 5;
        if (acc_kind == 3'd1 && m_r[f_idx] == 0) x_code = 6;
        if (acc_kind == 3'd2 && m_w[f_idx] == 0) x_code = 7;
      end
    end
    x_fault = (x_code != 0);
  endtask

  task automatic step(input string tag);
    predict();
    @(posedge clk);
    #1;
    if (wr_en) begin
      m_valid[wr_idx] = wr_valid; m_vpage[wr_idx] = int'(wr_vpage);
      m_tag[wr_idx] = int'(wr_tag); m_glob[wr_idx] = wr_global;
      m_frame[wr_idx] = int'(wr_frame);
      m_r[wr_idx] = wr_rd; m_w[wr_idx] = wr_wr; m_x[wr_idx] = wr_ex;
    end
    check(tag, hit, x_hit, "hit");
    check(tag, int'(frame), x_frame, "frame");
    check(tag, fault, x_fault, "fault");
    check(tag, fault_code, x_code, "code");
    check(tag, dside, x_dside, "dside");
    req = 1'b0; wr_en = 1'b0;
  endtask

  task automatic put(input int idx, input int v, input int vp, input int tg, input int gl,
                     input int fr, input int r, input int w, input int x);
    wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_valid = v[0]; wr_vpage = VPN_W'(vp);
    wr_tag = PID_W'(tg); wr_global = gl[0]; wr_frame = PFN_W'(fr);
    wr_rd = r[0]; wr_wr = w[0]; wr_ex = x[0];
    step("R11");
  endtask

  task automatic look(input string tag, input int kind, input int vp, input int tg,
                      input int pe, input int ex);
    req = 1'b1; acc_kind = 3'(kind); vpage = VPN_W'(vp); proc_tag = PID_W'(tg);
    pid_chk_en = pe[0]; in_exc = ex[0];
    step(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < ENTRIES; i++) m_valid[i] = 0;
    #(CLK_PERIOD * 3);
    // R1: reset values
    check("R1", hit, 0, "hit"); check("R1", int'(frame), 0, "frame");
    check("R1", fault, 0, "fault"); check("R1", fault_code, 0, "code");
    check("R1", dside, 0, "dside");
    rst_n = 1'b1;
    @(negedge clk);
    // R1/R4: empty table misses
    look("R1", 0, 'h100, 5, 1, 0);
    look("R4", 1, 'h100, 5, 1, 0);
    // fill table
    put(0, 1, 'h100, 5, 0, 'hA1, 1, 1, 1);
    put(1, 1, 'h200, 9, 1, 'hB2, 1, 0, 0);
    put(2, 1, 'h100, 5, 0, 'hC3, 0, 0, 0);
    put(3, 1, 'h300, 7, 0, 'hD4, 0, 0, 1);
    put(5, 1, 'h400, 3, 0, 'hE5, 0, 0, 0);
    // R2 and R3: duplicate tag resolves to entry 0
    look("R3", 0, 'h100, 5, 1, 0);
    look("R2", 2, 'h100, 5, 1, 0);
    // R2: global and disabled tag check
    look("R2", 1, 'h200, 44, 1, 0);
    look("R2", 0, 'h300, 99, 0, 0);
    look("R2", 0, 'h300, 99, 1, 0);
    // R7: rights faults
    look("R7", 0, 'h200, 9, 1, 0);
    look("R7", 2, 'h200, 9, 1, 1);
    look("R7", 1, 'h300, 7, 1, 0);
    // R5/R6: nested misses
    look("R5", 0, 'h777, 1, 1, 1);
    look("R6", 2, 'h777, 1, 1, 1);
    look("R6", 2, 'h777, 1, 1, 0);
    // R10: idle cycles hold
    step("R10"); step("R10");
    // R8: maintenance on a no-rights page
    look("R8", 4, 'h400, 3, 1, 0);
    look("R8", 6, 'h400, 3, 1, 1);
    look("R8", 6, 'h999, 3, 1, 1);
    // R9: index ops and unused kind
    look("R9", 3, 'h999, 3, 1, 1);
    look("R9", 5, 'h100, 5, 1, 0);
    look("R9", 7, 'h200, 9, 1, 0);
    // sweep of every kind over several pages and flag settings
    for (int k = 0; k < 8; k++)
      for (int p = 0; p < 4; p++)
        for (int e = 0; e < 2; e++)
          look("R4", k, (p == 3) ? 'h555 : ('h100 * (p + 1)), 7, 1, e);
    // R11: write and lookup in the same cycle see old contents
    wr_en = 1'b1; wr_idx = '0; wr_valid = 1'b1; wr_vpage = VPN_W'('h100);
    wr_tag = PID_W'(5); wr_global = 1'b0; wr_frame = PFN_W'('hF0);
    wr_rd = 1'b1; wr_wr = 1'b1; wr_ex = 1'b1;
    req = 1'b1; acc_kind = 3'd1; vpage = VPN_W'('h100); proc_tag = PID_W'(5);
    pid_chk_en = 1'b1; in_exc = 1'b0;
    step("R11");
    look("R11", 1, 'h100, 5, 1, 0);
    // R11: invalidate entry 0 and 2 so page misses
    put(0, 0, 'h100, 5, 0, 0, 0, 0, 0);
    put(2, 0, 'h100, 5, 0, 0, 0, 0, 0);
    look("R11", 0, 'h100, 5, 1, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule